// File: doc/BRIEF.md
# I2C SCL Clock Generator

This block is the timebase behind an I2C master engine. From the peripheral clock it derives an internal tick, using a prescaler that divides by one more than a small divide field. It then builds each SCL bit period out of those ticks. Both the divide field and the period step field arrive packed in one configuration word. The period in ticks is a fixed 20, plus 8 for each step, plus a small rounding count. The rounding count is a design parameter and stands for the rise time, the fall time and the internal delay.

The master engine asserts `gen_en` and pulses `start_req` when a transfer begins. The generator first holds SCL high for a programmable setup delay, which separates the first SDA edge from the first SCL edge. It then alternates low and high phases. On each transition it emits a single-cycle strobe, and it also emits a data-change strobe and a sample strobe at fixed points inside the phases. During the high phase the sensed SCL line is watched, so that a target holding the clock low (clock stretching) pauses the phase count. Pin drivers and protocol sequencing are left to the surrounding logic.

Top module: `scl_timebase`

## Requirements
- R1: `tick_o` pulses for one clock every CDF+1 clocks while `gen_en` is high, where CDF is `div_cfg[CDF_W-1:0]` (CDF_W = 3 by default). The divider must keep REF_HZ/(CDF+1) below TICK_MAX_HZ (20 MHz).
- R2: The step field STEP is the six bits directly above CDF, `div_cfg[CDF_W+5:CDF_W]`. One SCL period, measured from `fall_o` to the next `fall_o`, lasts P = 20 + 8×STEP + RND ticks (RND = 3 by default).
- R3: The low phase lasts ceil(P/2) ticks, from `fall_o` to `rise_o`. The high phase lasts the remaining floor(P/2) ticks, from `rise_o` to the next `fall_o`. `scl_o` is 0 exactly during the low phase.
- R4: After `start_req` is sampled, `scl_o` stays high and `setup_o` stays high for `setup_cfg`+2 ticks before the first `fall_o`. A value of 15 gives 17 ticks. From the `start_req` cycle to the first `fall_o`, this is (setup_cfg+2)×(CDF+1)+1 clocks.
- R5: `chg_o` pulses one tick after each `fall_o`. No two of `fall_o`, `rise_o`, `chg_o` and `smp_o` are ever high in the same cycle.
- R6: `smp_o` pulses floor(H/2) ticks after `rise_o`, where H = floor(P/2) is the high-phase length.
- R7: While the high phase is running and `scl_sense` reads 0, the high-phase count holds and SCL is not pulled low. After `scl_sense` returns high, `fall_o` follows within H ticks.
- R8: While `gen_en` is low, the block returns to idle one cycle later and stays there: `scl_o` = 1, no strobes, no `tick_o`, and `start_req` has no effect. When `gen_en` is raised again without a `start_req`, the block stays idle with SCL high.
- R9: A `start_req` during a running transfer restarts the block. In the next cycle `scl_o` = 1 and `setup_o` = 1, and the full setup delay of R4 follows.
- R10: After reset, `scl_o` = 1 and `tick_o`, `setup_o` and all strobes are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Synchronous active-low reset |
| gen_en | input | 1 | Generator enable |
| start_req | input | 1 | One-cycle request that restarts the sequence with a setup delay |
| div_cfg | input | CDF_W+6 | Packed divider word {STEP, CDF} |
| setup_cfg | input | 4 | First-bit setup value; the delay is this value + 2 ticks |
| scl_sense | input | 1 | Sensed level of the SCL line |
| tick_o | output | 1 | Internal tick enable |
| scl_o | output | 1 | Requested SCL level (1 = released) |
| fall_o | output | 1 | Strobe: SCL driven low |
| rise_o | output | 1 | Strobe: SCL released high |
| chg_o | output | 1 | Strobe: point at which SDA may change |
| smp_o | output | 1 | Strobe: point at which SDA is sampled |
| setup_o | output | 1 | High during the first-bit setup delay |

## Verification
The assertions check several properties on every cycle. The four strobes never overlap. Each fall or rise strobe agrees with the SCL level. The count stays frozen while a target stretches the clock. Disabling the block forces it idle, and a start request enters the setup state. The configured tick rate stays under its ceiling. The bench's scenarios are needed to show the actual durations, because these depend on the packed field positions and on arithmetic over several configurations: tick spacing, setup delay, the ceil/floor split of the phases, the strobe offsets and the full period. Only the bench's scenarios show the delay that follows the release of a stretch, and that a start request is ignored while the block is disabled.

// File: rtl/scl_gen_pkg.sv
// Package: shared phase encoding for the SCL clock generator.
// Assumes nothing beyond being compiled before the modules that import it.
package scl_gen_pkg;
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_SETUP = 2'd1,
        PH_LOW   = 2'd2,
        PH_HIGH  = 2'd3
    } scl_phase_e;
endpackage

// File: rtl/scl_cfg_decode.sv
// Module: scl_cfg_decode
// Splits the packed divider word into its prescale and step fields and
// derives the phase lengths, the sample point and the setup delay in ticks.
// Assumes: STEP_W bits sit directly above CDF_W bits; purely combinational.
module scl_cfg_decode #(
    parameter int CDF_W   = 3,
    parameter int STEP_W  = 6,
    parameter int RND     = 3,
    parameter int SETUP_W = 4,
    parameter int PER_W   = 10
) (
    input  logic [CDF_W+STEP_W-1:0] div_cfg,
    input  logic [SETUP_W-1:0]      setup_cfg,
    output logic [CDF_W-1:0]        cdf,
    output logic [PER_W-1:0]        low_len,
    output logic [PER_W-1:0]        high_len,
    output logic [PER_W-1:0]        smp_at,
    output logic [PER_W-1:0]        setup_len
);
    localparam logic [3:0] RND_V = 4'(RND);

    logic [STEP_W-1:0] step;
    logic [PER_W-1:0]  per_len;

    // Field extraction and period arithmetic.
    always_comb begin
        cdf       = div_cfg[CDF_W-1:0];
        step      = div_cfg[CDF_W +: STEP_W];
        per_len   = PER_W'(20) + (PER_W'(step) << 3) + PER_W'(RND_V);
        low_len   = (per_len + PER_W'(1)) >> 1;
        high_len  = per_len - low_len;
        smp_at    = (high_len >> 1) - PER_W'(1);
        setup_len = PER_W'(setup_cfg) + PER_W'(2);
    end
endmodule

// File: rtl/scl_prescale.sv
// Module: scl_prescale
// Divides the input clock by (cdf+1) and emits a one-cycle tick enable.
// Assumes: restart realigns the count so the first tick lands cdf+1 clocks later.
module scl_prescale #(
    parameter int CDF_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic [CDF_W-1:0] cdf,
    output logic             tick
);
    logic [CDF_W-1:0] pcnt;

    // Free-running modulo (cdf+1) counter, cleared when idle or restarted.
    always_ff @(posedge clk) begin
        if (!rst_n)                pcnt <= '0;
        else if (!run || restart)  pcnt <= '0;
        else if (pcnt == cdf)      pcnt <= '0;
        else                       pcnt <= pcnt + CDF_W'(1);
    end

    // Tick on the terminal count.
    assign tick = run && !restart && (pcnt == cdf);
endmodule

// File: rtl/scl_phase_seq.sv
// Module: scl_phase_seq
// Sequences setup, low and high phases in units of ticks and produces the
// registered SCL level plus fall, rise, data-change and sample strobes.
// Assumes: low_len and high_len are at least 10; scl_sense mirrors the bus.
module scl_phase_seq
    import scl_gen_pkg::*;
#(
    parameter int PER_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             start,
    input  logic             tick,
    input  logic             scl_sense,
    input  logic [PER_W-1:0] low_len,
    input  logic [PER_W-1:0] high_len,
    input  logic [PER_W-1:0] smp_at,
    input  logic [PER_W-1:0] setup_len,
    output logic             scl_o,
    output logic             fall_o,
    output logic             rise_o,
    output logic             chg_o,
    output logic             smp_o,
    output logic             setup_o
);
    scl_phase_e       st, st_n;
    logic [PER_W-1:0] cnt, cnt_n;
    logic             fall_n, rise_n, chg_n, smp_n;

    // Next-state and strobe decision for the current tick.
    always_comb begin
        st_n   = st;
        cnt_n  = cnt;
        fall_n = 1'b0;
        rise_n = 1'b0;
        chg_n  = 1'b0;
        smp_n  = 1'b0;
        if (!en) begin
            st_n  = PH_IDLE;
            cnt_n = '0;
        end else if (start) begin
            st_n  = PH_SETUP;
            cnt_n = '0;
        end else if (tick) begin
            unique case (st)
                PH_SETUP: begin
                    if (cnt == setup_len - PER_W'(1)) begin
                        st_n   = PH_LOW;
                        cnt_n  = '0;
                        fall_n = 1'b1;
                    end else begin
                        cnt_n = cnt + PER_W'(1);
                    end
                end
                PH_LOW: begin
                    chg_n = (cnt == '0);
                    if (cnt == low_len - PER_W'(1)) begin
                        st_n   = PH_HIGH;
                        cnt_n  = '0;
                        rise_n = 1'b1;
                    end else begin
                        cnt_n = cnt + PER_W'(1);
                    end
                end
                PH_HIGH: begin
                    if (scl_sense) begin
                        smp_n = (cnt == smp_at);
                        if (cnt == high_len - PER_W'(1)) begin
                            st_n   = PH_LOW;
                            cnt_n  = '0;
                            fall_n = 1'b1;
                        end else begin
                            cnt_n = cnt + PER_W'(1);
                        end
                    end
                end
                default: begin
                    st_n = PH_IDLE;
                end
            endcase
        end
    end

    // State, count and strobe registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= PH_IDLE;
            cnt    <= '0;
            fall_o <= 1'b0;
            rise_o <= 1'b0;
            chg_o  <= 1'b0;
            smp_o  <= 1'b0;
        end else begin
            st     <= st_n;
            cnt    <= cnt_n;
            fall_o <= fall_n;
            rise_o <= rise_n;
            chg_o  <= chg_n;
            smp_o  <= smp_n;
        end
    end

    // SCL is pulled low only in the low phase.
    assign scl_o   = (st != PH_LOW);
    assign setup_o = (st == PH_SETUP);

    // R5: strobes are mutually exclusive.
    p_strobe_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({fall_o, rise_o, chg_o, smp_o}));
    // R3: fall strobe coincides with SCL low.
    p_fall_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        fall_o |-> !scl_o);
    // R3: rise strobe coincides with SCL released.
    p_rise_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |-> scl_o);
    // R7: a stretched high phase freezes its count.
    p_stretch_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !start && st == PH_HIGH && !scl_sense) |=>
            (st == PH_HIGH && $stable(cnt) && !fall_o));
    // R8: disabling forces idle on the next cycle.
    p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (scl_o && !setup_o && !fall_o && !rise_o && !chg_o && !smp_o));
    // R4, R9: a start request enters setup with SCL high.
    p_start_setup_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (en && start) |=> (setup_o && scl_o));
endmodule

// File: rtl/scl_timebase.sv
// Module: scl_timebase (top)
// I2C SCL clock generator: prescaler, field decode and phase sequencer.
// Assumes: REF_HZ is the functional frequency of clk; configuration is
// changed only while disabled or together with a start request.
module scl_timebase #(
    parameter int          CDF_W       = 3,
    parameter int          RND         = 3,
    parameter int          SETUP_W     = 4,
    parameter int unsigned REF_HZ      = 100_000_000,
    parameter int unsigned TICK_MAX_HZ = 20_000_000
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 gen_en,
    input  logic                 start_req,
    input  logic [CDF_W+5:0]     div_cfg,
    input  logic [SETUP_W-1:0]   setup_cfg,
    input  logic                 scl_sense,
    output logic                 tick_o,
    output logic                 scl_o,
    output logic                 fall_o,
    output logic                 rise_o,
    output logic                 chg_o,
    output logic                 smp_o,
    output logic                 setup_o
);
    localparam int STEP_W  = 6;
    localparam int PER_MAX = 20 + 8 * ((1 << STEP_W) - 1) + 16;
    localparam int PER_W   = $clog2(PER_MAX + 1);

    logic [CDF_W-1:0] cdf;
    logic [PER_W-1:0] low_len, high_len, smp_at, setup_len;

    scl_cfg_decode #(
        .CDF_W(CDF_W), .STEP_W(STEP_W), .RND(RND),
        .SETUP_W(SETUP_W), .PER_W(PER_W)
    ) u_dec (
        .div_cfg  (div_cfg),
        .setup_cfg(setup_cfg),
        .cdf      (cdf),
        .low_len  (low_len),
        .high_len (high_len),
        .smp_at   (smp_at),
        .setup_len(setup_len)
    );

    scl_prescale #(.CDF_W(CDF_W)) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (gen_en),
        .restart(start_req),
        .cdf    (cdf),
        .tick   (tick_o)
    );

    scl_phase_seq #(.PER_W(PER_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (gen_en),
        .start    (start_req),
        .tick     (tick_o),
        .scl_sense(scl_sense),
        .low_len  (low_len),
        .high_len (high_len),
        .smp_at   (smp_at),
        .setup_len(setup_len),
        .scl_o    (scl_o),
        .fall_o   (fall_o),
        .rise_o   (rise_o),
        .chg_o    (chg_o),
        .smp_o    (smp_o),
        .setup_o  (setup_o)
    );

    // R1: the configured tick rate stays under its ceiling while enabled.
    p_tick_rate_r1: assert property (@(posedge clk) disable iff (!rst_n)
        gen_en |-> ((64'(REF_HZ) / (64'(cdf) + 64'd1)) < 64'(TICK_MAX_HZ)));
    // R8: no tick while disabled.
    p_tick_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !gen_en |-> !tick_o);
endmodule

// File: tb/sim_scl_timebase.sv
module sim_scl_timebase;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       gen_en = 1'b0;
    logic       start_req = 1'b0;
    logic [8:0] div_cfg = '0;
    logic [3:0] setup_cfg = 4'hF;
    logic       stretch = 1'b0;
    logic       scl_sense;
    logic       tick_o, scl_o, fall_o, rise_o, chg_o, smp_o, setup_o;
    int         cyc = 0;
    int         tests = 0;
    int         fails = 0;

    localparam int RND = 3;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;
    assign scl_sense = scl_o & ~stretch;

    scl_timebase u0 (
        .clk(clk), .rst_n(rst_n), .gen_en(gen_en), .start_req(start_req),
        .div_cfg(div_cfg), .setup_cfg(setup_cfg), .scl_sense(scl_sense),
        .tick_o(tick_o), .scl_o(scl_o), .fall_o(fall_o), .rise_o(rise_o),
        .chg_o(chg_o), .smp_o(smp_o), .setup_o(setup_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic chk_rng(input string req, input int act, input int lo, input int hi);
        tests++;
        if (act < lo || act > hi) begin
            fails++;
            $display("FAIL %s: actual=%0d expected=%0d..%0d", req, act, lo, hi);
        end
    endtask

    function automatic logic sig_of(input int sel);
        case (sel)
            0: return fall_o;
            1: return rise_o;
            2: return chg_o;
            3: return smp_o;
            default: return tick_o;
        endcase
    endfunction

    task automatic wait_for(input int sel, output int at);
        at = -1;
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            if (sig_of(sel)) begin
                at = cyc;
                break;
            end
        end
    endtask

    task automatic configure(input int cdf, input int step, input int setup);
        @(negedge clk);
        gen_en    = 1'b0;
        @(negedge clk);
        div_cfg   = {6'(step), 3'(cdf)};
        setup_cfg = 4'(setup);
        gen_en    = 1'b1;
    endtask

    task automatic do_start(output int c0);
        @(negedge clk);
        start_req = 1'b1;
        c0 = cyc;
        @(negedge clk);
        start_req = 1'b0;
    endtask

    // R10: idle outputs after reset.
    task automatic t_reset();
        @(negedge clk);
        chk("R10 scl", int'(scl_o), 1);
        chk("R10 strobes+tick+setup", int'({fall_o, rise_o, chg_o, smp_o, tick_o, setup_o}), 0);
    endtask

    // R1: tick spacing equals cdf+1 clocks.
    task automatic t_tick(input int cdf);
        int c0, a, b;
        configure(cdf, 0, 15);
        do_start(c0);
        wait_for(4, a);
        wait_for(4, b);
        chk("R1 tick gap", b - a, cdf + 1);
    endtask

    // R2..R6: full timing of one start and one whole period.
    task automatic t_period(input int cdf, input int step, input int setup);
        int k, p, l, h, d, c0, f1, cg, r, s, f2;
        k = cdf + 1; p = 20 + 8 * step + RND; l = (p + 1) / 2; h = p - l; d = setup + 2;
        configure(cdf, step, setup);
        do_start(c0);
        wait_for(0, f1);
        chk("R4 start to first fall", f1 - c0, d * k + 1);
        wait_for(2, cg);
        chk("R5 fall to change", cg - f1, k);
        wait_for(1, r);
        chk("R3 low phase", r - f1, l * k);
        wait_for(3, s);
        chk("R6 rise to sample", s - r, (h / 2) * k);
        wait_for(0, f2);
        chk("R3 high phase", f2 - r, h * k);
        chk("R2 period", f2 - f1, p * k);
    endtask

    // R7: clock stretching in the high phase (config cdf=5, step=0).
    task automatic t_stretch();
        int r, g, nf, nl, k, h;
        k = 6; h = (20 + RND) - (20 + RND + 1) / 2;
        wait_for(1, r);
        stretch = 1'b1;
        nf = 0; nl = 0;
        for (int i = 0; i < 500; i++) begin
            @(negedge clk);
            if (fall_o) nf++;
            if (!scl_o) nl++;
        end
        chk("R7 no fall while stretched", nf, 0);
        chk("R7 scl released while stretched", nl, 0);
        stretch = 1'b0;
        r = cyc;
        wait_for(0, g);
        chk_rng("R7 fall after release", g - r, (h - 1) * k + 1, h * k);
    endtask

    // R9: restart during a running low phase.
    task automatic t_restart();
        int f, c0, f2;
        wait_for(0, f);
        do_start(c0);
        chk("R9 scl high after restart", int'(scl_o), 1);
        chk("R9 setup after restart", int'(setup_o), 1);
        wait_for(0, f2);
        chk("R9 restart to fall", f2 - c0, 17 * 6 + 1);
    endtask

    // R8: disable and re-enable without start.
    task automatic t_disable();
        int n;
        @(negedge clk);
        gen_en = 1'b0;
        @(negedge clk);
        chk("R8 scl after disable", int'(scl_o), 1);
        n = 0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (fall_o || rise_o || chg_o || smp_o || tick_o || !scl_o) n++;
        end
        chk("R8 quiet while disabled", n, 0);
        gen_en = 1'b1;
        n = 0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (fall_o || rise_o || chg_o || smp_o || setup_o || !scl_o) n++;
        end
        chk("R8 idle after re-enable", n, 0);
    endtask

    // R8: start request ignored while disabled.
    task automatic t_start_off();
        int n, c0;
        @(negedge clk);
        gen_en = 1'b0;
        do_start(c0);
        chk("R8 start ignored setup", int'(setup_o), 0);
        n = 0;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (fall_o || !scl_o) n++;
        end
        chk("R8 start ignored no fall", n, 0);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_tick(5);
        t_period(5, 0, 15);
        t_stretch();
        t_restart();
        t_disable();
        t_start_off();
        t_tick(7);
        t_period(7, 3, 15);
        t_period(6, 63, 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog: actual=hung expected=complete");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule